// File: doc/BRIEF.md
# FPU Exception Status Update Unit

This block folds a set of floating-point exceptions, raised by one arithmetic operation, into the numeric status word. It uses the exception mask field of the control word for this. It also works out which of those exceptions must trap, and it signals a numeric error for an unmasked divide-by-zero. A caller pulses `req_valid` for one cycle with the raised set and its side information: the C1 condition bit, the stack-fault bit, and whether the destination is a memory operand. One clock edge later the status word and the trap vector hold the new values and `done` pulses.

The update follows a fixed priority. Invalid operation wins over everything. Divide-by-zero comes next and records only itself. An unmasked denormal ends processing with a denormal-only trap. All other cases merge the raised set. Here the precision exception never traps, and C1 and the precision flag get special treatment when overflow or underflow is unmasked with a memory destination. The unit does not produce results and does not touch the register stack.

Top module: `fpu_exc_status_unit`

## Requirements
- R1: Exception bit positions are invalid 0, denormal 1, divide-by-zero 2, overflow 3, underflow 4, precision 5, and `cw_mask` uses the same positions (1 = masked). The trap vector is always a subset of the raised bits that are not masked, and it never contains precision.
- R2: When invalid or divide-by-zero is raised, the unmasked set is reduced to those two bits before any other use, so no other exception can trap.
- R3: If the unmasked set (after the R2 reduction, before any later removal) is not empty, status bits 7 (error summary) and 15 (busy) are set. This happens even if the final trap vector is empty.
- R4: With invalid raised, all raised exception bits plus the stack-fault input (status bit 6) and the C1 input (status bit 9) are ORed into the status word. If stack fault is present and the C1 input is 0, status bit 9 is cleared. The trap vector is the reduced unmasked set.
- R5: With divide-by-zero raised and invalid not raised, only status bit 2 is set (plus R3). If divide-by-zero is unmasked, one cycle with `done` pulses `ferr_pulse` when `numerr_en` is 1 and `irq13_pulse` otherwise. No other case pulses either output.
- R6: With unmasked denormal and neither invalid nor divide-by-zero raised, only status bit 1 is set (plus R3), and the trap vector is exactly 6'b000010.
- R7: In every other case, the raised bits, stack fault and C1 are ORed into the status word. If precision is raised with C1 input 0, status bit 9 is cleared. Status bits 0 to 4, once set, stay set until reset.
- R8: In the R7 case, if overflow or underflow is unmasked and `req_mem_dest` is 0, both are removed from the trap vector.
- R9: In the R7 case, if overflow or underflow is unmasked and `req_mem_dest` is 1, they stay in the trap vector. Status bit 9 is cleared, and status bit 5 is cleared unless it was already 1 before this update.
- R10: The status word, trap vector and pulses change on the first clock edge after a strobe, and `done` is high for exactly that one cycle. Without a strobe nothing changes. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle update strobe |
| req_exc | input | 6 | Raised exception set |
| req_c1 | input | 1 | C1 condition input |
| req_stk_fault | input | 1 | Stack-fault indication |
| req_mem_dest | input | 1 | Destination is a memory operand |
| cw_mask | input | 6 | Exception mask field of the control word |
| numerr_en | input | 1 | 1 routes numeric errors to the error pin, 0 to interrupt 13 |
| stat_word | output | 16 | Status word register |
| trap_vec | output | 6 | Unmasked exceptions that must trap |
| done | output | 1 | Update completed this cycle |
| irq13_pulse | output | 1 | Interrupt-13 request pulse |
| ferr_pulse | output | 1 | Numeric error signal pulse |

## Verification
Some properties hold on every cycle, and the assertions check those: the one-edge latency and the done pulse, a status word that stays still when idle, a trap vector that stays inside the unmasked set and never holds precision, the limit to invalid and divide-by-zero, the summary bits whenever something traps, the sticky low flags, the denormal-only trap, and which way a divide-by-zero error is routed. The exact status bits in each priority path depend on the previous status word and on the memory-destination flag. Only the bench's sweeps can show these: the C1 clearing rules, the conditional clearing of the precision flag, and the removal of overflow and underflow. The sweep covers every raised set against every mask, with both C1, stack-fault and destination values, and from a status word with and without precision already set.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
  localparam int EXC_W = 6;
  localparam int SW_W  = 16;

  localparam int B_INV = 0;
  localparam int B_DEN = 1;
  localparam int B_ZDV = 2;
  localparam int B_OVF = 3;
  localparam int B_UNF = 4;
  localparam int B_PRE = 5;
  localparam int B_STK = 6;
  localparam int B_SUM = 7;
  localparam int B_C1  = 9;
  localparam int B_BSY = 15;

  typedef logic [EXC_W-1:0] exc_t;
  typedef logic [SW_W-1:0]  sw_t;

  typedef enum logic [2:0] {
    P_IDLE    = 3'd0,
    P_INVALID = 3'd1,
    P_ZDIV    = 3'd2,
    P_DENORM  = 3'd3,
    P_GENERAL = 3'd4
  } path_e;

  localparam exc_t HARD_SET = exc_t'((1 << B_INV) | (1 << B_ZDV));
  localparam exc_t OVUF_SET = exc_t'((1 << B_OVF) | (1 << B_UNF));
  localparam exc_t PRE_BIT  = exc_t'(1 << B_PRE);
  localparam exc_t DEN_BIT  = exc_t'(1 << B_DEN);

  // raised exceptions not blocked by the mask field
  function automatic exc_t unmasked_raw(exc_t raised, exc_t mask);
    return raised & ~mask;
  endfunction

  // invalid / divide-by-zero hide every other report
  function automatic exc_t hard_reduce(exc_t raw, exc_t raised);
    return (|(raised & HARD_SET)) ? (raw & HARD_SET) : raw;
  endfunction

  // OR the exception set, stack fault and C1 into a status word
  function automatic sw_t merge_flags(sw_t sw, exc_t raised, logic stk, logic c1);
    return sw | sw_t'(raised) | (sw_t'(stk) << B_STK) | (sw_t'(c1) << B_C1);
  endfunction

  // summary and busy bits when anything is unmasked
  function automatic sw_t mark_summary(sw_t sw, exc_t live);
    sw_t r;
    r = sw;
    if (|live) begin
      r[B_SUM] = 1'b1;
      r[B_BSY] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/fxs_mask_filter.sv
module fxs_mask_filter
  import fxs_pkg::*;
(
  input  exc_t raised,
  input  exc_t mask,
  output exc_t live,
  output logic hard_hit
);
  exc_t raw;

  always_comb begin
    raw      = unmasked_raw(raised, mask);
    live     = hard_reduce(raw, raised);
    hard_hit = |(raised & HARD_SET);
  end
endmodule

// File: rtl/fxs_priority_path.sv
module fxs_priority_path
  import fxs_pkg::*;
(
  input  exc_t  raised,
  input  exc_t  live,
  input  logic  stk,
  input  logic  c1,
  input  logic  mem_dest,
  input  logic  zd_masked,
  input  logic  numerr_en,
  input  sw_t   old_sw,
  output sw_t   next_sw,
  output exc_t  next_trap,
  output logic  want_irq,
  output logic  want_ferr,
  output path_e path
);
  always_comb begin
    next_sw   = mark_summary(old_sw, live);
    next_trap = live;
    want_irq  = 1'b0;
    want_ferr = 1'b0;
    path      = P_IDLE;
    if (raised[B_INV]) begin
      path    = P_INVALID;
      next_sw = merge_flags(next_sw, raised, stk, c1);
      if (stk && !c1) next_sw[B_C1] = 1'b0;
    end else if (raised[B_ZDV]) begin
      path            = P_ZDIV;
      next_sw[B_ZDV]  = 1'b1;
      if (!zd_masked) begin
        want_ferr = numerr_en;
        want_irq  = !numerr_en;
      end
    end else if (raised[B_DEN] && live[B_DEN]) begin
      path           = P_DENORM;
      next_sw[B_DEN] = 1'b1;
      next_trap      = DEN_BIT;
    end else begin
      path    = P_GENERAL;
      next_sw = merge_flags(next_sw, raised, stk, c1);
      if (raised[B_PRE] && !c1) next_sw[B_C1] = 1'b0;
      next_trap = live & ~PRE_BIT;
      if (|(next_trap & OVUF_SET)) begin
        if (!mem_dest) begin
          next_trap = next_trap & ~OVUF_SET;
        end else begin
          next_sw[B_C1] = 1'b0;
          if (!old_sw[B_PRE]) next_sw[B_PRE] = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/fxs_state_regs.sv
module fxs_state_regs
  import fxs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  sw_t  next_sw,
  input  exc_t next_trap,
  input  logic want_irq,
  input  logic want_ferr,
  output sw_t  sw_q,
  output exc_t trap_q,
  output logic done_q,
  output logic irq_q,
  output logic ferr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '0;
      trap_q <= '0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      done_q <= load;
      irq_q  <= load && want_irq;
      ferr_q <= load && want_ferr;
      if (load) begin
        sw_q   <= next_sw;
        trap_q <= next_trap;
      end
    end
  end
endmodule

// File: rtl/fpu_exc_status_unit.sv
module fpu_exc_status_unit
  import fxs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [EXC_W-1:0] req_exc,
  input  logic             req_c1,
  input  logic             req_stk_fault,
  input  logic             req_mem_dest,
  input  logic [EXC_W-1:0] cw_mask,
  input  logic             numerr_en,
  output logic [SW_W-1:0]  stat_word,
  output logic [EXC_W-1:0] trap_vec,
  output logic             done,
  output logic             irq13_pulse,
  output logic             ferr_pulse
);
  exc_t  live_w;
  logic  hard_w;
  sw_t   next_sw_w;
  exc_t  next_trap_w;
  logic  want_irq_w;
  logic  want_ferr_w;
  path_e path_w;

  fxs_mask_filter u_mask (
    .raised   (req_exc),
    .mask     (cw_mask),
    .live     (live_w),
    .hard_hit (hard_w)
  );

  fxs_priority_path u_prio (
    .raised    (req_exc),
    .live      (live_w),
    .stk       (req_stk_fault),
    .c1        (req_c1),
    .mem_dest  (req_mem_dest),
    .zd_masked (cw_mask[B_ZDV]),
    .numerr_en (numerr_en),
    .old_sw    (stat_word),
    .next_sw   (next_sw_w),
    .next_trap (next_trap_w),
    .want_irq  (want_irq_w),
    .want_ferr (want_ferr_w),
    .path      (path_w)
  );

  fxs_state_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_valid),
    .next_sw   (next_sw_w),
    .next_trap (next_trap_w),
    .want_irq  (want_irq_w),
    .want_ferr (want_ferr_w),
    .sw_q      (stat_word),
    .trap_q    (trap_vec),
    .done_q    (done),
    .irq_q     (irq13_pulse),
    .ferr_q    (ferr_pulse)
  );

  // timing of the update
  assert_done_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);
  assert_no_spurious_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done);
  assert_idle_holds_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(stat_word) && $stable(trap_vec));

  // trap vector contents
  assert_trap_subset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (trap_vec & ~($past(req_exc) & ~$past(cw_mask))) == '0);
  assert_no_precision_trap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !trap_vec[B_PRE]);
  assert_hard_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hard_w |=> (trap_vec & ~HARD_SET) == '0);
  assert_summary_on_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && (trap_vec != '0) |-> stat_word[B_SUM] && stat_word[B_BSY]);
  assert_denorm_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (path_w == P_DENORM) |=> trap_vec == DEN_BIT);

  // error signalling
  assert_one_error_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq13_pulse |-> !ferr_pulse);
  assert_irq_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq13_pulse |-> !$past(numerr_en));
  assert_ferr_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_pulse |-> $past(numerr_en));
  assert_error_only_zdiv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (path_w != P_ZDIV) |=> !irq13_pulse && !ferr_pulse);

  // low exception flags are sticky
  assert_sticky_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stat_word[4:0] & $past(stat_word[4:0])) == $past(stat_word[4:0]));
endmodule

// File: tb/fpu_exc_status_unit_tb_top.sv
module fpu_exc_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_exc = '0;
  logic        req_c1 = 1'b0;
  logic        req_stk_fault = 1'b0;
  logic        req_mem_dest = 1'b0;
  logic [5:0]  cw_mask = '0;
  logic        numerr_en = 1'b0;
  logic [15:0] stat_word;
  logic [5:0]  trap_vec;
  logic        done;
  logic        irq13_pulse;
  logic        ferr_pulse;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [15:0] model_sw = '0;

  fpu_exc_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_exc(req_exc),
    .req_c1(req_c1), .req_stk_fault(req_stk_fault), .req_mem_dest(req_mem_dest),
    .cw_mask(cw_mask), .numerr_en(numerr_en), .stat_word(stat_word),
    .trap_vec(trap_vec), .done(done), .irq13_pulse(irq13_pulse), .ferr_pulse(ferr_pulse)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 195000) begin
      failures = failures + 1;
      $display("FAIL R10 watchdog: actual cycles=%0d expected below 195000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Independent reference, written bit by bit from the requirements
  task automatic ref_update(input logic [5:0] e, input logic [5:0] m, input logic c1,
                            input logic stk, input logic st, input logic ne,
                            input logic [15:0] old, output logic [15:0] s,
                            output logic [5:0] t, output logic irq, output logic ferr,
                            output string tag);
    logic [5:0] act;
    act = 6'b0;
    for (int i = 0; i < 6; i++) act[i] = e[i] && !m[i];
    if (e[0] || e[2]) act = {3'b0, act[2], 1'b0, act[0]};   // R2
    s = old; irq = 0; ferr = 0;
    if (act != 0) begin s[7] = 1; s[15] = 1; end            // R3
    if (e[0]) begin
      tag = "R4";
      for (int i = 0; i < 6; i++) if (e[i]) s[i] = 1;
      if (stk) s[6] = 1;
      if (c1) s[9] = 1;
      if (stk && !c1) s[9] = 0;
      t = act;
    end else if (e[2]) begin
      tag = "R5";
      s[2] = 1;
      t = act;
      if (!m[2]) begin if (ne) ferr = 1; else irq = 1; end
    end else if (e[1] && !m[1]) begin
      tag = "R6";
      s[1] = 1;
      t = 6'b000010;
    end else begin
      tag = "R7";
      for (int i = 0; i < 6; i++) if (e[i]) s[i] = 1;
      if (stk) s[6] = 1;
      if (c1) s[9] = 1;
      if (e[5] && !c1) s[9] = 0;
      t = act;
      t[5] = 0;
      if (t[3] || t[4]) begin
        if (!st) begin tag = "R8"; t[3] = 0; t[4] = 0; end
        else begin tag = "R9"; s[9] = 0; if (!old[5]) s[5] = 0; end
      end
    end
  endtask

  task automatic check(input string tag, input logic [15:0] es, input logic [5:0] et,
                       input logic eirq, input logic eferr, input logic edone);
    checks = checks + 1;
    if (stat_word !== es || trap_vec !== et || irq13_pulse !== eirq ||
        ferr_pulse !== eferr || done !== edone) begin
      failures = failures + 1;
      $display("FAIL %s (R1 R2 R3 R10): sw=%h/%h trap=%b/%b irq=%b/%b ferr=%b/%b done=%b/%b (actual/expected)",
               tag, stat_word, es, trap_vec, et, irq13_pulse, eirq, ferr_pulse, eferr, done, edone);
    end
  endtask

  task automatic drive(input logic [5:0] e, input logic [5:0] m, input logic c1,
                       input logic stk, input logic st, input logic ne);
    req_valid = 1; req_exc = e; cw_mask = m; req_c1 = c1;
    req_stk_fault = stk; req_mem_dest = st; numerr_en = ne;
  endtask

  initial begin
    logic [15:0] s;
    logic [5:0]  t;
    logic        irq, ferr;
    string       tag;
    repeat (2) @(negedge clk);
    check("R10 reset", 16'h0, 6'h0, 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    check("R10 idle after reset", 16'h0, 6'h0, 0, 0, 0);

    // directed: unmasked divide-by-zero with error pin, then idle
    drive(6'b000100, 6'b111011, 0, 0, 0, 1);
    @(negedge clk);
    req_valid = 0;
    check("R5 ferr route", 16'h8084, 6'b000100, 0, 1, 1);
    @(negedge clk);
    check("R10 pulse ends, status held", 16'h8084, 6'b000100, 0, 0, 0);

    // exhaustive sweep: raised set x mask x C1 x stack fault x destination
    for (int e = 0; e < 64; e++) begin
      for (int m = 0; m < 64; m++) begin
        for (int f = 0; f < 8; f++) begin
          logic c1v, stkv, stv, nev, pre;
          c1v  = f[0]; stkv = f[1]; stv = f[2];
          nev  = e[1] ^ m[0] ^ f[0];
          pre  = e[3] ^ m[5] ^ f[1];
          @(negedge clk);
          rst_n = 0; req_valid = 0;
          @(negedge clk);
          rst_n = 1;
          model_sw = 16'h0;
          if (pre) begin
            // precision already recorded, all masked, C1 input 1
            drive(6'b100000, 6'b111111, 1, 0, 0, 0);
            ref_update(6'b100000, 6'b111111, 1, 0, 0, 0, model_sw, s, t, irq, ferr, tag);
            model_sw = s;
            @(negedge clk);
          end
          drive(6'(e), 6'(m), c1v, stkv, stv, nev);
          ref_update(6'(e), 6'(m), c1v, stkv, stv, nev, model_sw, s, t, irq, ferr, tag);
          @(negedge clk);
          req_valid = 0;
          check(tag, s, t, irq, ferr, 1);
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule